// File: doc/BRIEF.md
# Standby Request Qualifier and Output Sequencer

This block turns two board-level standby request pins into a single qualified standby condition and uses it to gate a set of regulator enables and general-purpose outputs. Each pin is first brought into the 32 kHz clock domain through a short flip-flop chain. Each pin then has its own polarity bit, so a board can drive either pin active high or active low. Standby is qualified only when both corrected pins are active together. The power controller must also report the On mode, and no low-power-off command may be pending. The off command always wins over standby.

Entry into standby waits for a programmable number of slow-clock cycles (0 to 3). If qualification drops during that wait, the count starts over, so a short pulse on the pins has no effect. Exit takes effect on the next slow-clock edge with no extra wait. Each output has a standby-response bit. Where that bit is set, an active standby disables the regulator or drives the general-purpose output low. Where it is clear, the output follows its normal value. A readback bus always returns the programmed configuration bits, never the standby-modified outputs.

Top module: `stby_seq`

## Requirements
- R1: The corrected value of each pin is the synchronised pin XOR its invert bit (`inv_a` for `pin_a`, `inv_b` for `pin_b`). A corrected value of 1 means that pin requests standby.
- R2: Standby qualifies only when both corrected pins are 1. If either is 0, no output is modified.
- R3: When `pwr_on` is 0, the pins have no effect and every output equals its normal value.
- R4: When `off_cmd` is 1, standby is overridden and every output equals its normal value, even while both pins request standby.
- R5: Entry delay encoding of `dly_sel`: 00 = none, 01 = one, 10 = two, 11 = three extra slow-clock cycles. A pin change that completes qualification reaches the outputs on the (3 + dly_sel)-th rising clock edge after it: two synchroniser edges, one state edge and the delay.
- R6: Exit has no delay. A pin change that removes qualification restores the outputs on the 3rd rising edge after it, whatever `dly_sel` is.
- R7: If qualification drops before the delay expires, the count restarts from zero. A qualified pulse shorter than the delay leaves every output unchanged, and a later request again waits the full delay.
- R8: While standby is active, `reg_en_out[i] = reg_en_nrm[i] & ~reg_stby_msk[i]` and `gpo_out[j] = gpo_nrm[j] & ~gpo_stby_msk[j]`. A clear mask bit leaves its output unaffected.
- R9: `rb_data` = {gpo_stby_msk, reg_stby_msk, dly_sel, inv_b, inv_a}, with `inv_a` at bit 0. It reflects the programmed values whether or not standby is active.
- R10: During reset (`rst_n` = 0) and after it, until a request qualifies, every output equals its normal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | First standby request pin (asynchronous) |
| pin_b | input | 1 | Second standby request pin (asynchronous) |
| inv_a | input | 1 | Polarity invert bit for pin_a |
| inv_b | input | 1 | Polarity invert bit for pin_b |
| dly_sel | input | 2 | Entry delay selector in slow-clock cycles |
| pwr_on | input | 1 | Power controller is in On mode |
| off_cmd | input | 1 | Low-power-off command pending |
| reg_en_nrm | input | 8 | Normal regulator enables |
| reg_stby_msk | input | 8 | Per-regulator standby-response bits |
| gpo_nrm | input | 4 | Normal general-purpose output values |
| gpo_stby_msk | input | 4 | Per-output standby-response bits |
| reg_en_out | output | 8 | Effective regulator enables |
| gpo_out | output | 4 | Effective general-purpose output values |
| rb_data | output | 16 | Readback of the programmed configuration |

## Verification
All 64 combinations of both pin levels, both polarity bits, the mode bit and the off command are swept and left to settle. This separates a correct two-pin AND under each polarity from a single-pin decode, a missing inversion, a missing mode gate or a lost off-command priority. Each of the four delay codes is timed edge by edge on both entry and exit, which exposes off-by-one counts and any delay wrongly applied on exit. A sub-delay pulse followed by a full request shows whether the counter restarts. Mixed mask and normal-value patterns under active standby show per-bit gating and check that readback is left unchanged.

// File: rtl/stby_pkg.sv
package stby_pkg;
   localparam int unsigned STBY_DLY_W   = 2;
   localparam int unsigned STBY_SYNC_N  = 2;
   localparam int unsigned STBY_PIN_N   = 2;
   typedef logic [STBY_DLY_W-1:0] stby_dly_t;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("stby_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/stby_qual.sv
module stby_qual #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] pins_s,
   input  logic [N-1:0] inv,
   input  logic         pwr_on,
   input  logic         off_cmd,
   output logic         qual
);
   generate
      if (N < 1) begin : g_bad_n
         $error("stby_qual: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] corr;
   assign corr = pins_s ^ inv;
   // all corrected requests, On mode, and no off command pending
   assign qual = (&corr) & pwr_on & ~off_cmd;
endmodule

// File: rtl/stby_dly.sv
module stby_dly #(
   parameter int unsigned DW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          qual,
   input  logic [DW-1:0] dly_sel,
   output logic          act
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("stby_dly: DW must be at least 1");
      end
   endgenerate

   logic [DW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         act <= 1'b0;
      end else if (!qual) begin
         cnt <= '0;
         act <= 1'b0;
      end else if (!act) begin
         if (cnt == dly_sel) act <= 1'b1;
         else                cnt <= cnt + 1'b1;
      end
   end

   assert_exit_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !qual |=> !act);
   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !qual |=> (cnt == '0));
   assert_entry_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act) |-> ($past(qual) && ($past(cnt) == $past(dly_sel))));
   assert_hold_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && act) |=> act);
endmodule

// File: rtl/stby_gate.sv
module stby_gate #(
   parameter int unsigned W = 8
) (
   input  logic         act,
   input  logic [W-1:0] nrm,
   input  logic [W-1:0] msk,
   output logic [W-1:0] out
);
   generate
      if (W < 1) begin : g_bad_w
         $error("stby_gate: W must be at least 1");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign out[i] = nrm[i] & ~(act & msk[i]);
      end
   endgenerate
endmodule

// File: rtl/stby_seq.sv
module stby_seq
   import stby_pkg::*;
#(
   parameter int unsigned N_REG = 8,
   parameter int unsigned N_GPO = 4,
   localparam int unsigned RB_W = N_GPO + N_REG + STBY_DLY_W + STBY_PIN_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_a,
   input  logic             pin_b,
   input  logic             inv_a,
   input  logic             inv_b,
   input  logic [1:0]       dly_sel,
   input  logic             pwr_on,
   input  logic             off_cmd,
   input  logic [N_REG-1:0] reg_en_nrm,
   input  logic [N_REG-1:0] reg_stby_msk,
   input  logic [N_GPO-1:0] gpo_nrm,
   input  logic [N_GPO-1:0] gpo_stby_msk,
   output logic [N_REG-1:0] reg_en_out,
   output logic [N_GPO-1:0] gpo_out,
   output logic [RB_W-1:0]  rb_data
);
   generate
      if (N_REG < 1 || N_GPO < 1) begin : g_bad_cnt
         $error("stby_seq: output counts must be at least 1");
      end
      if (STBY_DLY_W != 2) begin : g_bad_dly
         $error("stby_seq: delay field width must be 2");
      end
   endgenerate

   logic [STBY_PIN_N-1:0] pins_s;
   logic                  qual;
   logic                  stby_act;

   stby_sync #(.STAGES(STBY_SYNC_N), .W(STBY_PIN_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({pin_b, pin_a}), .q(pins_s));

   stby_qual #(.N(STBY_PIN_N)) u_qual (
      .pins_s(pins_s), .inv({inv_b, inv_a}), .pwr_on(pwr_on),
      .off_cmd(off_cmd), .qual(qual));

   stby_dly #(.DW(STBY_DLY_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .qual(qual), .dly_sel(dly_sel), .act(stby_act));

   stby_gate #(.W(N_REG)) u_reg_gate (
      .act(stby_act), .nrm(reg_en_nrm), .msk(reg_stby_msk), .out(reg_en_out));

   stby_gate #(.W(N_GPO)) u_gpo_gate (
      .act(stby_act), .nrm(gpo_nrm), .msk(gpo_stby_msk), .out(gpo_out));

   // readback carries programmed bits only (R9)
   assign rb_data = {gpo_stby_msk, reg_stby_msk, dly_sel, inv_b, inv_a};

   assert_off_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
      off_cmd |=> !stby_act);
   assert_on_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> !stby_act);
   assert_need_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(&(pins_s ^ {inv_b, inv_a})) |=> !stby_act);
endmodule

// File: tb/stby_seq_tb_top.sv
module stby_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_a = 1'b0, pin_b = 1'b0, inv_a = 1'b0, inv_b = 1'b0;
   logic [1:0] dly_sel = 2'b01;
   logic       pwr_on = 1'b1, off_cmd = 1'b0;
   logic [7:0] reg_en_nrm = 8'hFF, reg_stby_msk = 8'hFF;
   logic [3:0] gpo_nrm = 4'hF, gpo_stby_msk = 4'hF;
   logic [7:0] reg_en_out;
   logic [3:0] gpo_out;
   logic [15:0] rb_data;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   stby_seq dut_i (
      .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
      .inv_a(inv_a), .inv_b(inv_b), .dly_sel(dly_sel), .pwr_on(pwr_on),
      .off_cmd(off_cmd), .reg_en_nrm(reg_en_nrm), .reg_stby_msk(reg_stby_msk),
      .gpo_nrm(gpo_nrm), .gpo_stby_msk(gpo_stby_msk),
      .reg_en_out(reg_en_out), .gpo_out(gpo_out), .rb_data(rb_data));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // expected outputs for a given standby state
   function automatic logic [11:0] exp_out(input logic st);
      logic [7:0] r;
      logic [3:0] g;
      r = st ? (reg_en_nrm & ~reg_stby_msk) : reg_en_nrm;
      g = st ? (gpo_nrm & ~gpo_stby_msk) : gpo_nrm;
      return {g, r};
   endfunction

   // count negedges until reg_en_out reaches the target value
   task automatic measure(input logic [7:0] target, output int lat);
      lat = 99;
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         if (lat == 99 && reg_en_out === target) lat = k;
      end
   endtask

   initial begin
      int lat;
      logic st;
      // R10: reset state
      pin_a = 1'b1; pin_b = 1'b1;
      wait_neg(3);
      check("R10 reset", {20'd0, gpo_out, reg_en_out}, {20'd0, exp_out(1'b0)});
      pin_a = 1'b0; pin_b = 1'b0;
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(8);
      check("R10 after reset", {20'd0, gpo_out, reg_en_out}, {20'd0, exp_out(1'b0)});

      // exhaustive decode sweep, dly=3 to cover worst entry time
      dly_sel = 2'b11;
      for (int c = 0; c < 64; c++) begin
         pin_a = c[0]; pin_b = c[1]; inv_a = c[2]; inv_b = c[3];
         pwr_on = c[4]; off_cmd = c[5];
         wait_neg(8);
         st = (c[0] ^ c[2]) & (c[1] ^ c[3]) & c[4] & ~c[5];
         if (!c[4])     check("R3 mode gate", {20'd0, gpo_out, reg_en_out}, {20'd0, exp_out(st)});
         else if (c[5]) check("R4 off priority", {20'd0, gpo_out, reg_en_out}, {20'd0, exp_out(st)});
         else           check("R1 R2 decode", {20'd0, gpo_out, reg_en_out}, {20'd0, exp_out(st)});
      end

      // delay sweep on entry and exit
      pwr_on = 1'b1; off_cmd = 1'b0; inv_a = 1'b0; inv_b = 1'b0;
      pin_a = 1'b0; pin_b = 1'b0;
      wait_neg(8);
      for (int d = 0; d < 4; d++) begin
         dly_sel = d[1:0];
         pin_a = 1'b1; pin_b = 1'b1;
         measure(8'h00, lat);
         check("R5 entry latency", lat, d + 3);
         pin_a = 1'b0;
         measure(8'hFF, lat);
         check("R6 exit latency", lat, 3);
         pin_b = 1'b0;
         wait_neg(2);
      end

      // R7: short pulse with dly=3, then full request
      dly_sel = 2'b11;
      pin_a = 1'b1; pin_b = 1'b1;
      wait_neg(2);
      pin_a = 1'b0; pin_b = 1'b0;
      measure(8'h00, lat);
      check("R7 glitch ignored", lat, 99);
      pin_a = 1'b1; pin_b = 1'b1;
      wait_neg(3);
      pin_b = 1'b0;
      wait_neg(1);
      pin_b = 1'b1;
      measure(8'h00, lat);
      check("R7 restart full delay", lat, 6);

      // R8/R9: masks under active standby
      for (int p = 0; p < 8; p++) begin
         reg_stby_msk = 8'hA5 ^ (8'h11 << p[2:0]);
         reg_en_nrm   = 8'h3C + 8'(p * 37);
         gpo_stby_msk = 4'(p * 3);
         gpo_nrm      = 4'hF ^ 4'(p);
         inv_a = p[0]; inv_b = p[1];
         pin_a = ~p[0]; pin_b = ~p[1];
         wait_neg(8);
         check("R8 reg gate", {24'd0, reg_en_out}, {24'd0, reg_en_nrm & ~reg_stby_msk});
         check("R8 gpo gate", {28'd0, gpo_out}, {28'd0, gpo_nrm & ~gpo_stby_msk});
         check("R9 readback", {16'd0, rb_data},
               {16'd0, gpo_stby_msk, reg_stby_msk, dly_sel, p[1], p[0]});
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule